// File: doc/BRIEF.md
# Power-Mode Clock Gate Register Bank

This block holds a bank of clock-gate control words, one per peripheral. Each word is split into four nibbles, one per clock domain, and the low two bits of every nibble select a gating policy for that domain. Each cycle the block combines the stored policy with the CPU power state (run, wait or stop) and the peripheral's own clock-enable request. It then produces a registered gated-enable bit for every gate and domain pair. The gated-enable bits drive clock-tree cells elsewhere.

Software selects a policy by writing a whole control word to a gate. A write replaces the word outright, with no merge against the old value. A write becomes visible on the gated outputs at the same clock edge that stores it, and so does a change of power mode or of the enable request.

Top module: `pm_clock_gate_bank`

## Requirements
- R1: During reset every gated output is 0. After reset, reading any gate returns 0x3333, meaning policy 3 in every domain.
- R2: Policy 0 holds that domain's gated output at 0 in every power mode. A word of 0x0000 sets policy 0 in all four domains.
- R3: Policy 1 passes the enable only when the mode is run (0). A word of 0x1111 sets policy 1 in all four domains.
- R4: Policy 2 passes the enable when the mode is run (0) or wait (1). A word of 0x2222 sets policy 2 in all four domains.
- R5: Policy 3 passes the enable in every power mode. A word of 0x3333 sets policy 3 in all four domains.
- R6: The power mode is encoded as 0 for run, 1 for wait and 2 for stop. The unused code 3 behaves as stop. In stop, only policy 3 passes the enable.
- R7: Domain d of a gate takes its policy from data bits [4d+1:4d]. It drives output bit gate*4+d. Each domain is evaluated independently of the others.
- R8: Bits [3:2] of every nibble are reserved. They always read as 0, and data written to them has no effect on the stored policy or on the outputs.
- R9: A low enable request for a gate forces all four of that gate's outputs to 0, whatever the policy.
- R10: The outputs are registered. Each rising edge loads the result of the mode, the enable request and the policy, where the policy includes any write accepted at that same edge.
- R11: A write replaces the addressed gate's word entirely and leaves every other gate unchanged. Writes to addresses at or above the gate count are dropped, and reads from such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_addr | input | 3 | Gate index to write |
| wr_data | input | 16 | Control word to write |
| rd_addr | input | 3 | Gate index to read |
| rd_data | output | 16 | Stored control word of the gate at rd_addr, reserved bits 0 |
| pwr_mode | input | 2 | CPU power state: 0 run, 1 wait, 2 stop |
| clk_en_in | input | 8 | Per-gate clock-enable request |
| gated_en | output | 32 | Registered gated enable, bit gate*4+domain |

## Verification
The assertions assume that every input is stable and known at each rising edge while rst_n is high, and that reset is applied for at least one edge before checking starts. The bench changes all inputs on the falling edge and holds them through the following rising edge. It compares results one time unit after the edge, so inputs never move near the sampling point. The stimulus visits mode code 3 only after the three defined modes have been covered.

// File: rtl/pm_clock_gate_bank.sv
module pm_clock_gate_bank #(
  parameter int NUM_GATES = 8,
  parameter int DOMAINS   = 4,
  parameter int AW        = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [DOMAINS*4-1:0]         wr_data,
  input  logic [AW-1:0]                rd_addr,
  output logic [DOMAINS*4-1:0]         rd_data,
  input  logic [1:0]                   pwr_mode,
  input  logic [NUM_GATES-1:0]         clk_en_in,
  output logic [NUM_GATES*DOMAINS-1:0] gated_en
);

  localparam int NIB   = 4;
  localparam int PW    = 2;
  localparam int SLOTS = NUM_GATES * DOMAINS;

  localparam logic [1:0] POL_OFF    = 2'd0;
  localparam logic [1:0] POL_RUN    = 2'd1;
  localparam logic [1:0] POL_RUNWT  = 2'd2;
  localparam logic [1:0] POL_ALWAYS = 2'd3;

  localparam logic [1:0] MODE_RUN  = 2'd0;
  localparam logic [1:0] MODE_WAIT = 2'd1;

  logic [SLOTS*PW-1:0] pol_q;
  logic [SLOTS*PW-1:0] pol_nxt;
  logic [SLOTS-1:0]    pass_nxt;

  function automatic logic policy_pass(input logic [1:0] pol, input logic [1:0] mode);
    case (pol)
      POL_OFF:   policy_pass = 1'b0;
      POL_RUN:   policy_pass = (mode == MODE_RUN);
      POL_RUNWT: policy_pass = (mode == MODE_RUN) || (mode == MODE_WAIT);
      default:   policy_pass = 1'b1;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(g));
    for (genvar d = 0; d < DOMAINS; d++) begin : g_dom
      localparam int S = g * DOMAINS + d;
      assign pol_nxt[S*PW +: PW] = hit ? wr_data[d*NIB +: PW] : pol_q[S*PW +: PW];
      assign pass_nxt[S] = clk_en_in[g] & policy_pass(pol_nxt[S*PW +: PW], pwr_mode);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q    <= '1;
      gated_en <= '0;
    end else begin
      pol_q    <= pol_nxt;
      gated_en <= pass_nxt;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NUM_GATES) begin
      for (int d = 0; d < DOMAINS; d++) begin
        rd_data[d*NIB +: PW] = pol_q[(int'(rd_addr)*DOMAINS + d)*PW +: PW];
      end
    end
  end

  logic reserved_sink;
  always_comb begin
    reserved_sink = 1'b0;
    for (int d = 0; d < DOMAINS; d++) begin
      reserved_sink = reserved_sink ^ (^wr_data[d*NIB+PW +: NIB-PW]);
    end
  end
  logic unused_ok;
  assign unused_ok = reserved_sink;

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & {DOMAINS{4'b1100}}) == '0);

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_chk
    for (genvar d = 0; d < DOMAINS; d++) begin : g_dchk
      localparam int S = g * DOMAINS + d;
      // R9
      no_req_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_in[g] |=> !gated_en[S]);
      // R2
      off_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_q[S*PW +: PW] == POL_OFF) |-> !gated_en[S]);
      // R6
      stop_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode[1] |=> (!gated_en[S] || pol_q[S*PW +: PW] == POL_ALWAYS));
      // R5
      always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_in[g] |=> (gated_en[S] || pol_q[S*PW +: PW] != POL_ALWAYS));
    end
  end

endmodule

// File: tb/pm_clock_gate_bank_tb.sv
module pm_clock_gate_bank_tb;
  localparam int G = 8;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  pwr_mode = '0;
  logic [7:0]  clk_en_in = '0;
  logic [31:0] gated_en;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] v;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [1:0] mpol [G][D];

  always #4 clk = ~clk;

  pm_clock_gate_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwr_mode(pwr_mode),
    .clk_en_in(clk_en_in), .gated_en(gated_en)
  );

  function automatic logic ref_pass(input logic [1:0] p, input logic [1:0] m);
    if (p == 2'd0) return 1'b0;
    if (p == 2'd1) return m == 2'd0;
    if (p == 2'd2) return (m == 2'd0) || (m == 2'd1);
    return 1'b1;
  endfunction

  task automatic step(input logic [1:0] m, input logic [7:0] en, input logic we,
                      input logic [2:0] a, input logic [15:0] dat, input string tag);
    exp_t e;
    @(negedge clk);
    pwr_mode = m; clk_en_in = en; wr_en = we; wr_addr = a; wr_data = dat;
    if (we) for (int d = 0; d < D; d++) mpol[a][d] = dat[d*4 +: 2];
    e.v = '0;
    for (int g = 0; g < G; g++)
      for (int d = 0; d < D; d++)
        e.v[g*4+d] = en[g] & ref_pass(mpol[g][d], m);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    rd_addr = a;
    #1;
    n_run++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: rd gate %0d got %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (gated_en !== e.v) begin
        n_fail++;
        $display("FAIL %s: gated_en got %h expected %h", e.tag, gated_en, e.v);
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int g = 0; g < G; g++) for (int d = 0; d < D; d++) mpol[g][d] = 2'd3;
    clk_en_in = 8'hFF;
    repeat (3) @(negedge clk);
    n_run++;
    if (gated_en !== 32'h0) begin
      n_fail++;
      $display("FAIL R1: reset gated_en got %h expected %h", gated_en, 32'h0);
    end
    rst_n = 1'b1;
    for (int g = 0; g < G; g++) chk_rd(3'(g), 16'h3333, "R1");

    // R5 always-on in all modes
    step(2'd0, 8'hFF, 1'b0, 3'd0, 16'h0, "R5 run");
    step(2'd1, 8'hFF, 1'b0, 3'd0, 16'h0, "R5 wait");
    step(2'd2, 8'hFF, 1'b0, 3'd0, 16'h0, "R5 stop");

    // R2 + R10: write effective at the same edge
    step(2'd0, 8'hFF, 1'b1, 3'd0, 16'h0000, "R10 R2 write");
    step(2'd1, 8'hFF, 1'b0, 3'd0, 16'h0, "R2 wait");
    step(2'd2, 8'hFF, 1'b0, 3'd0, 16'h0, "R2 stop");

    // R3
    step(2'd0, 8'hFF, 1'b1, 3'd1, 16'h1111, "R3 run");
    step(2'd1, 8'hFF, 1'b0, 3'd0, 16'h0, "R3 wait");
    step(2'd2, 8'hFF, 1'b0, 3'd0, 16'h0, "R3 stop");

    // R4 and R6 alias
    step(2'd0, 8'hFF, 1'b1, 3'd2, 16'h2222, "R4 run");
    step(2'd1, 8'hFF, 1'b0, 3'd0, 16'h0, "R4 wait");
    step(2'd2, 8'hFF, 1'b0, 3'd0, 16'h0, "R4 R6 stop");
    step(2'd3, 8'hFF, 1'b0, 3'd0, 16'h0, "R6 code3");
    step(2'd1, 8'hFF, 1'b0, 3'd0, 16'h0, "R10 mode back");

    // R7 mixed nibbles
    step(2'd0, 8'hFF, 1'b1, 3'd3, 16'h0123, "R7 run");
    step(2'd1, 8'hFF, 1'b0, 3'd0, 16'h0, "R7 wait");
    step(2'd2, 8'hFF, 1'b0, 3'd0, 16'h0, "R7 stop");
    chk_rd(3'd3, 16'h0123, "R7");

    // R8 reserved bits
    step(2'd0, 8'hFF, 1'b1, 3'd4, 16'hFFFF, "R8 ones");
    chk_rd(3'd4, 16'h3333, "R8");
    step(2'd0, 8'hFF, 1'b1, 3'd5, 16'hC0C0, "R8 reserved only");
    chk_rd(3'd5, 16'h0000, "R8");
    step(2'd0, 8'hFF, 1'b0, 3'd0, 16'h0, "R8 outputs");

    // R9 enable request low
    step(2'd0, 8'h5A, 1'b0, 3'd0, 16'h0, "R9 pattern a");
    step(2'd2, 8'hA5, 1'b0, 3'd0, 16'h0, "R9 pattern b");
    step(2'd0, 8'h00, 1'b0, 3'd0, 16'h0, "R9 all low");

    // R11 whole-word replace, others untouched
    step(2'd0, 8'hFF, 1'b1, 3'd3, 16'h1000, "R11 replace");
    chk_rd(3'd3, 16'h1000, "R11");
    chk_rd(3'd2, 16'h2222, "R11");
    chk_rd(3'd6, 16'h3333, "R11");
    step(2'd1, 8'hFF, 1'b1, 3'd7, 16'h2121, "R11 last gate");
    chk_rd(3'd7, 16'h2121, "R11");
    chk_rd(3'd0, 16'h0000, "R11");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule